// File: doc/BRIEF.md
# Register-Port Chunky-to-Planar Converter

This peripheral turns packed 8-bit pixels into bitplane words through one 32-bit register location. The host stores a group of 32 pixels as eight 32-bit words, four pixels per word, all to the same address. It then reads eight words back from that address. Each word read back is one bitplane, holding one bit from every pixel of the group.

Two small counters drive the block, one for loading and one for draining. They make a single address behave as a load-eight, unload-eight transposition engine. Larger images are converted by repeating the sequence once per 32-pixel group.

The transpose is a fixed wiring network over the stored words, so the planes are ready as soon as the last word is stored. A host may abandon a readback part-way by writing a new word, which begins a fresh group.

Top module: `c2p_regport`

## Requirements
- R1: A synchronous active-high reset puts the block in load phase with both indices at zero and clears the word buffer; a selected read right after reset returns 0.
- R2: In load phase, each selected write (`sel`=1, `wr_en`=1) stores `wdata` into the next of eight word slots in order. The eighth write switches the block to drain phase with the read index at 0.
- R3: In drain phase, the k-th selected read (k = 0..7) returns bitplane k. Pixel n (0..31) is byte `3 - n%4` of written word `n/4`, so pixel 0 is bits 31:24 of the first word. Bit `31 - n` of plane k equals bit k of pixel n.
- R4: A selected read in the cycle right after the eighth write returns plane 0, with no wait cycles.
- R5: After the eighth read the block returns to load phase, and a further selected read returns 0 until eight more words are written.
- R6: A selected write during drain phase abandons the readback. That write becomes word 0 of a new group, and the next eight reads after seven more writes return the planes of the new group.
- R7: A selected read during load phase returns 0 and does not move the load position. Words written after it continue the same group.
- R8: Strobes with `sel`=0 are ignored: they neither store data nor advance either index.
- R9: `rdata` is 0 in every cycle that has no selected read in drain phase. A cycle with both strobes selected counts as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Address decode hit for the data register |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Chunky word, four pixels, first pixel in the top byte |
| rdata | output | 32 | Plane word during drain-phase reads, 0 otherwise |

## Verification
The embedded assertions check the sequencing rules on every cycle:
- entry to drain phase on the eighth write;
- return to load phase after the eighth read;
- the abort-and-restart on a write during drain;
- the frozen load position on an early read;
- plane 0 appearing on the first read after the group completes.

The transpose itself, and the bit positions of every plane, can only be shown by the bench. It compares each readback word against its own model across patterned and pseudo-random groups. The bench also covers the directed cases: reset part-way through a group, strobes without select, and reads outside drain phase.

// File: rtl/c2p_pkg.sv
package c2p_pkg;

    localparam int PIX_W       = 8;
    localparam int WORD_W      = 32;
    localparam int PIX_PER_WRD = WORD_W / PIX_W;
    localparam int GROUP_WORDS = PIX_W;
    localparam int IDX_W       = $clog2(GROUP_WORDS);

    typedef enum logic {
        PH_LOAD  = 1'b0,
        PH_DRAIN = 1'b1
    } phase_e;

    typedef struct packed {
        logic wr;
        logic rd;
    } bus_hit_t;

    // Decode one bus cycle; a write wins over a read in the same cycle.
    function automatic bus_hit_t decode_hit(input logic sel, input logic wr, input logic rd);
        bus_hit_t h;
        h.wr = sel & wr;
        h.rd = sel & rd & ~wr;
        return h;
    endfunction

endpackage

// File: rtl/c2p_seq_ctrl.sv
module c2p_seq_ctrl
    import c2p_pkg::*;
#(
    parameter int NUM   = GROUP_WORDS,
    parameter int IW    = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_hit_t      hit,
    output phase_e        phase,
    output logic [IW-1:0] wr_idx,
    output logic [IW-1:0] rd_idx,
    output logic [IW-1:0] slot,
    output logic          store
);
    localparam logic [IW-1:0] LAST = IW'(NUM - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_LOAD;
            wr_idx <= '0;
            rd_idx <= '0;
        end else if (hit.wr) begin
            if (phase == PH_DRAIN) begin
                phase  <= PH_LOAD;
                wr_idx <= IW'(1);
                rd_idx <= '0;
            end else if (wr_idx == LAST) begin
                phase  <= PH_DRAIN;
                wr_idx <= '0;
                rd_idx <= '0;
            end else begin
                wr_idx <= wr_idx + 1'b1;
            end
        end else if (hit.rd && phase == PH_DRAIN) begin
            if (rd_idx == LAST) begin
                phase  <= PH_LOAD;
                rd_idx <= '0;
            end else begin
                rd_idx <= rd_idx + 1'b1;
            end
        end
    end

    // A write during drain restarts the group at slot 0.
    always_comb begin
        store = hit.wr;
        slot  = (phase == PH_DRAIN) ? '0 : wr_idx;
    end

    // R2
    drain_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (hit.wr && phase == PH_LOAD && wr_idx == LAST) |=> (phase == PH_DRAIN && rd_idx == '0));

    // R5
    drain_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (hit.rd && phase == PH_DRAIN && rd_idx == LAST) |=> (phase == PH_LOAD && wr_idx == '0));

    // R6
    abort_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (hit.wr && phase == PH_DRAIN) |=> (phase == PH_LOAD && wr_idx == IW'(1)));

    // R7
    early_read_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (hit.rd && phase == PH_LOAD) |=> (phase == PH_LOAD && $stable(wr_idx)));

endmodule

// File: rtl/c2p_chunky_buf.sv
module c2p_chunky_buf
    import c2p_pkg::*;
#(
    parameter int W   = WORD_W,
    parameter int NUM = GROUP_WORDS,
    parameter int IW  = IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              store,
    input  logic [IW-1:0]     slot,
    input  logic [W-1:0]      wdata,
    output logic [NUM*W-1:0]  flat
);
    logic [W-1:0] mem [NUM];

    for (genvar i = 0; i < NUM; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= '0;
            else if (store && slot == IW'(i))
                mem[i] <= wdata;
        end
        // Word 0 sits at the top of the flat vector.
        assign flat[(NUM-i)*W-1 -: W] = mem[i];
    end

endmodule

// File: rtl/c2p_bit_transpose.sv
module c2p_bit_transpose
    import c2p_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int PW = PIX_W
) (
    input  logic [PW*W-1:0]       flat,
    output logic [PW-1:0][W-1:0]  planes
);
    localparam int TOT = PW * W;

    // Pixel n occupies flat[TOT-1-PW*n -: PW]; its bit p lands at plane p, bit W-1-n.
    for (genvar p = 0; p < PW; p++) begin : g_plane
        for (genvar n = 0; n < W; n++) begin : g_pix
            assign planes[p][W-1-n] = flat[TOT - PW*(n+1) + p];
        end
    end

endmodule

// File: rtl/c2p_regport.sv
module c2p_regport
    import c2p_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int PW = PIX_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sel,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata
);
    localparam int NUM = PW;
    localparam int IW  = $clog2(NUM);

    bus_hit_t             hit;
    phase_e               phase;
    logic [IW-1:0]        wr_idx;
    logic [IW-1:0]        rd_idx;
    logic [IW-1:0]        slot;
    logic                 store;
    logic [NUM*W-1:0]     flat;
    logic [PW-1:0][W-1:0] planes;

    assign hit = decode_hit(sel, wr_en, rd_en);

    c2p_seq_ctrl #(.NUM(NUM), .IW(IW)) u_ctrl (
        .clk(clk), .rst(rst), .hit(hit), .phase(phase),
        .wr_idx(wr_idx), .rd_idx(rd_idx), .slot(slot), .store(store)
    );

    c2p_chunky_buf #(.W(W), .NUM(NUM), .IW(IW)) u_buf (
        .clk(clk), .rst(rst), .store(store), .slot(slot),
        .wdata(wdata), .flat(flat)
    );

    c2p_bit_transpose #(.W(W), .PW(PW)) u_xpose (
        .flat(flat), .planes(planes)
    );

    always_comb begin
        rdata = '0;
        if (hit.rd && phase == PH_DRAIN)
            rdata = planes[rd_idx];
    end

    // R4
    first_plane_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(hit.wr) && $past(phase) == PH_LOAD && $past(wr_idx) == IW'(NUM-1) && hit.rd)
            |-> (rdata == planes[0]));

    // R9
    quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
        (!sel) |-> (rdata == '0));

endmodule

// File: tb/c2p_regport_tb.sv
`timescale 1ns/1ps
module c2p_regport_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        sel, wr_en, rd_en;
    logic [31:0] wdata;
    logic [31:0] rdata;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    c2p_regport u_dut (
        .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata)
    );

    localparam int NVEC = 24;
    localparam logic [31:0] VEC [NVEC] = '{
        32'h8040_2010, 32'h0804_0201, 32'h0102_0408, 32'h1020_4080,
        32'hFF00_FF00, 32'h00FF_00FF, 32'hAA55_AA55, 32'h0F0F_F0F0,
        32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000,
        32'h0000_0001, 32'h8000_0000, 32'h1234_5678, 32'h9ABC_DEF0,
        32'h0102_0304, 32'h0506_0708, 32'h090A_0B0C, 32'h0D0E_0F10,
        32'hC3C3_3C3C, 32'h7E81_817E, 32'hDEAD_BEEF, 32'hCAFE_F00D
    };

    logic [31:0] grp [8];
    logic [31:0] lfsr = 32'h1ACE_B00C;

    function automatic logic [31:0] model_plane(input int p);
        logic [31:0] r = '0;
        for (int n = 0; n < 32; n++) begin
            logic [7:0] px = grp[n/4][31-8*(n%4) -: 8];
            r[31-n] = px[p];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [31:0] d, input logic s = 1'b1);
        @(negedge clk);
        sel = s; wr_en = 1'b1; wdata = d;
        @(posedge clk); #1;
        sel = 1'b0; wr_en = 1'b0;
    endtask

    task automatic bus_read(output logic [31:0] v, input logic s = 1'b1);
        @(negedge clk);
        sel = s; rd_en = 1'b1;
        #1 v = rdata;
        @(posedge clk); #1;
        sel = 1'b0; rd_en = 1'b0;
    endtask

    task automatic write_group();
        for (int i = 0; i < 8; i++) bus_write(grp[i]);
    endtask

    task automatic read_planes(input string req);
        logic [31:0] v;
        for (int p = 0; p < 8; p++) begin
            bus_read(v);
            check(req, v, model_plane(p));
        end
    endtask

    function automatic logic [31:0] next_rand(input logic [31:0] x);
        logic [31:0] y = x;
        y ^= y << 13; y ^= y >> 17; y ^= y << 5;
        return y;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        sel = 0; wr_en = 0; rd_en = 0; wdata = '0; rst = 1'b1;
        repeat (3) @(posedge clk); #1 rst = 1'b0;

        // R1 reset state: read returns zero
        bus_read(v);
        check("R1", v, 32'h0);

        // R2 R3 R4 table-driven groups
        for (int g = 0; g < NVEC/8; g++) begin
            for (int i = 0; i < 8; i++) grp[i] = VEC[g*8+i];
            write_group();
            read_planes("R3");
        end

        // R3 pseudo-random groups
        for (int g = 0; g < 6; g++) begin
            for (int i = 0; i < 8; i++) begin
                lfsr = next_rand(lfsr);
                grp[i] = lfsr;
            end
            write_group();
            read_planes("R3");
            // R5 back in load phase
            bus_read(v);
            check("R5", v, 32'h0);
        end

        // R4 read immediately after eighth write
        for (int i = 0; i < 8; i++) grp[i] = VEC[i+8];
        for (int i = 0; i < 7; i++) bus_write(grp[i]);
        @(negedge clk); sel = 1; wr_en = 1; wdata = grp[7];
        @(negedge clk); wr_en = 0; rd_en = 1;
        #1 check("R4", rdata, model_plane(0));
        @(posedge clk); #1 sel = 0; rd_en = 0;
        for (int p = 1; p < 8; p++) begin
            bus_read(v);
            check("R4", v, model_plane(p));
        end

        // R7 early read in load phase
        for (int i = 0; i < 8; i++) grp[i] = VEC[i+16];
        for (int i = 0; i < 3; i++) bus_write(grp[i]);
        bus_read(v);
        check("R7", v, 32'h0);
        for (int i = 3; i < 8; i++) bus_write(grp[i]);
        read_planes("R7");

        // R6 write during drain aborts and restarts
        for (int i = 0; i < 8; i++) grp[i] = VEC[i];
        write_group();
        bus_read(v); bus_read(v); bus_read(v);
        for (int i = 0; i < 8; i++) grp[i] = VEC[i+4];
        write_group();
        read_planes("R6");

        // R8 unselected strobes ignored
        for (int i = 0; i < 8; i++) grp[i] = VEC[i+12];
        for (int i = 0; i < 4; i++) bus_write(grp[i]);
        bus_write(32'hFFFF_FFFF, 1'b0);
        for (int i = 4; i < 8; i++) bus_write(grp[i]);
        bus_read(v, 1'b0);
        check("R8", v, 32'h0);
        read_planes("R8");

        // R9 simultaneous strobes count as write; idle rdata zero
        for (int i = 0; i < 8; i++) grp[i] = VEC[i+2];
        for (int i = 0; i < 7; i++) bus_write(grp[i]);
        @(negedge clk); sel = 1; wr_en = 1; rd_en = 1; wdata = grp[7];
        #1 check("R9", rdata, 32'h0);
        @(posedge clk); #1 sel = 0; wr_en = 0; rd_en = 0;
        #1 check("R9", rdata, 32'h0);
        read_planes("R9");

        // R1 reset mid-group clears progress
        for (int i = 0; i < 3; i++) bus_write(32'h5A5A_5A5A);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        bus_read(v);
        check("R1", v, 32'h0);
        for (int i = 0; i < 8; i++) grp[i] = VEC[i+10];
        write_group();
        read_planes("R1");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule